// File: doc/BRIEF.md
# Adaptive Commutation Delay Timer

This block decides when a sensorless brushless motor drive should step to its next winding state. A zero-crossing detector elsewhere toggles a level signal each time the back-EMF of the floating phase crosses the centre-tap. The block measures the time between two toggles and then issues a commutation request part of the way into the following interval. Two digital up/down counters stand in for a pair of timing capacitors and swap roles on every toggle. One counter measures the interval now running by counting up. The other replays the interval it measured last time by counting down at twice that rate, so its request lands near the middle of the new interval.

Time is measured in ticks of a clock-enable input. While the blanking flag is high after a state change, the measuring counter stops, so the recorded interval is a little short. The commutation therefore lands slightly before the midpoint, which allows for winding inductance. If a toggle arrives before the replaying counter has finished, the block commutes at once and moves on.

Top module: `comm_delay_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `commute` is low, both counters are idle, and ticks without any toggle of `zc_tgl` never raise `commute`.
- R2: Every change of `zc_tgl` in either direction is a toggle. On a toggle, the measuring counter hands over to replay and the other counter restarts measurement from the threshold level (THRESH, default 100). The first toggle after reset never raises `commute`, and neither counter is ever replaying at the same time as the other.
- R3: On each tick with `blank` low, the measuring counter rises by CHG_STEP (default 20). With `blank` high it holds its value.
- R4: On each tick, the replaying counter falls by DIS_STEP (default 40), and `blank` has no effect on it. A commutation occurs on the tick that brings it to the threshold level or below. With n unblanked measuring ticks, the pulse follows the ceil(n/2)-th tick of the replay.
- R5: Without a tick in a cycle, no counter moves. `commute` only rises in the cycle after a tick or a toggle.
- R6: The measuring counter saturates at the all-ones value (65535 for CNT_W = 16) and does not wrap. After 3400 measuring ticks, the replay takes 1636 ticks.
- R7: A toggle that finds a counter still replaying raises `commute` in the next cycle and swaps the roles as in R2.
- R8: `commute` is high for exactly one clock cycle per commutation. In the cycle right after a pulse, the replaying counter holds its value, so two pulses are never adjacent.
- R9: A counter that saw no unblanked tick before the handover goes idle and produces no commutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Time-base enable, one count step per high cycle |
| blank | input | 1 | High while the measuring counter must pause |
| zc_tgl | input | 1 | Zero-crossing level, toggles once per crossing |
| commute | output | 1 | One-cycle commutation request |

## Verification
The assertions assume that `zc_tgl` is synchronous to `clk` and stays low through reset, because the edge detector starts from a low sample. They also assume that ticks and toggles are plain single-cycle levels, sampled only at the rising edge. The stimulus changes every input on the falling clock edge, holds `zc_tgl` low until reset is released, and keeps `tick_en` low in each cycle that carries a toggle. That way, each measured interval is an exact count of unblanked ticks.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;

    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_CHG  = 2'd1,
        TM_DIS  = 2'd2
    } tmr_mode_e;

    localparam int NUM_TMR = 2;

    typedef struct packed {
        logic sel;
        logic pulse;
    } ctl_t;

endpackage

// File: rtl/cdt_zc_edge.sv
`timescale 1ns/1ps
module cdt_zc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_in,
    output logic zc_edge
);
    logic zc_d, zc_q;

    always_comb begin
        zc_d    = zc_in;
        zc_edge = zc_in ^ zc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zc_q <= 1'b0;
        else        zc_q <= zc_d;
    end
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int THRESH   = 100,
    parameter int CHG_STEP = 20,
    parameter int DIS_STEP = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_chg,
    input  logic             load_dis,
    input  logic             tick,
    input  logic             blank,
    input  logic             hold,
    output logic [CNT_W-1:0] val_o,
    output tmr_mode_e        mode_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] VMAX    = '1;
    localparam logic [CNT_W-1:0] BASE_V  = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] CHG_V   = CNT_W'(CHG_STEP);
    localparam logic [CNT_W-1:0] DIS_V   = CNT_W'(DIS_STEP);
    localparam logic [CNT_W-1:0] CHG_LIM = VMAX - CHG_V;
    localparam logic [CNT_W-1:0] DIS_LIM = CNT_W'(THRESH + DIS_STEP);

    typedef struct packed {
        tmr_mode_e        mode;
        logic [CNT_W-1:0] val;
    } tmr_t;

    tmr_t st_d, st_q;
    logic step_dn;

    always_comb begin
        st_d    = st_q;
        step_dn = !load_chg && !load_dis && tick && !hold && (st_q.mode == TM_DIS);
        done_o  = step_dn && (st_q.val <= DIS_LIM);
        if (load_chg) begin
            st_d.mode = TM_CHG;
            st_d.val  = BASE_V;
        end else if (load_dis) begin
            if (st_q.mode == TM_CHG && st_q.val > BASE_V) st_d.mode = TM_DIS;
            else begin
                st_d.mode = TM_IDLE;
                st_d.val  = BASE_V;
            end
        end else if (tick) begin
            if (st_q.mode == TM_CHG && !blank) begin
                st_d.val = (st_q.val > CHG_LIM) ? VMAX : st_q.val + CHG_V;
            end else if (step_dn) begin
                if (done_o) begin
                    st_d.mode = TM_IDLE;
                    st_d.val  = BASE_V;
                end else begin
                    st_d.val = st_q.val - DIS_V;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= TM_IDLE;
            st_q.val  <= BASE_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o  = st_q.val;
    assign mode_o = st_q.mode;
endmodule

// File: rtl/comm_delay_timer.sv
`timescale 1ns/1ps
module comm_delay_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int THRESH   = 100,
    parameter int CHG_STEP = 20,
    parameter int DIS_STEP = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic blank,
    input  logic zc_tgl,
    output logic commute
);
    logic             zc_edge;
    logic [CNT_W-1:0] val_w  [NUM_TMR];
    tmr_mode_e        mode_w [NUM_TMR];
    logic             done_w [NUM_TMR];
    logic             forced;
    ctl_t             ctl_d, ctl_q;

    cdt_zc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .zc_in   (zc_tgl),
        .zc_edge (zc_edge)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        cdt_timer #(
            .CNT_W    (CNT_W),
            .THRESH   (THRESH),
            .CHG_STEP (CHG_STEP),
            .DIS_STEP (DIS_STEP)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_chg (zc_edge && (ctl_q.sel != 1'(i))),
            .load_dis (zc_edge && (ctl_q.sel == 1'(i))),
            .tick     (tick_en),
            .blank    (blank),
            .hold     (ctl_q.pulse),
            .val_o    (val_w[i]),
            .mode_o   (mode_w[i]),
            .done_o   (done_w[i])
        );
    end

    always_comb begin
        ctl_d  = ctl_q;
        forced = zc_edge && (mode_w[~ctl_q.sel] == TM_DIS);
        if (zc_edge) begin
            ctl_d.sel   = ~ctl_q.sel;
            ctl_d.pulse = forced;
        end else begin
            ctl_d.pulse = done_w[0] | done_w[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign commute = ctl_q.pulse;
endmodule

// File: rtl/cdt_chk.sv
`timescale 1ns/1ps
module cdt_chk
    import cdt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int THRESH = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             blank,
    input logic             zc_tgl,
    input logic             commute,
    input logic [CNT_W-1:0] val0,
    input logic [CNT_W-1:0] val1,
    input tmr_mode_e        mode0,
    input tmr_mode_e        mode1
);
    logic zc_prev;
    logic zc_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zc_prev <= 1'b0;
        else        zc_prev <= zc_tgl;
    end
    assign zc_ev = zc_tgl ^ zc_prev;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        commute |=> !commute); // R8
    AST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        commute |-> $past(tick_en || zc_ev)); // R5
    AST_EARLY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_ev && (mode0 == TM_DIS || mode1 == TM_DIS)) |=> commute); // R7
    AST_SINGLE_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode0 == TM_DIS && mode1 == TM_DIS)); // R2
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (val0 >= CNT_W'(THRESH)) && (val1 >= CNT_W'(THRESH))); // R4
    AST_BLANK_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == TM_CHG && blank && !zc_ev) |=> $stable(val0)); // R3
    AST_BLANK_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == TM_CHG && blank && !zc_ev) |=> $stable(val1)); // R3
endmodule

bind comm_delay_timer cdt_chk #(
    .CNT_W  (CNT_W),
    .THRESH (THRESH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .blank   (blank),
    .zc_tgl  (zc_tgl),
    .commute (commute),
    .val0    (val_w[0]),
    .val1    (val_w[1]),
    .mode0   (mode_w[0]),
    .mode1   (mode_w[1])
);

// File: tb/sim_comm_delay_timer.sv
`timescale 1ns/1ps
module sim_comm_delay_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic blank = 1'b0;
    logic zc_tgl = 1'b0;
    logic commute;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    comm_delay_timer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .blank   (blank),
        .zc_tgl  (zc_tgl),
        .commute (commute)
    );

    // {measuring ticks, blanked ticks among them, expected replay ticks (0 = none)}
    // R4 plain intervals, R3 blanked intervals, R9 empty interval
    localparam int NVEC = 8;
    localparam int VEC [NVEC][3] = '{
        '{10, 0, 5}, '{11, 0, 6}, '{1, 0, 1}, '{30, 0, 15},
        '{20, 4, 8}, '{5, 2, 2},  '{7, 7, 0}, '{0, 0, 0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; blank = 1'b0; zc_tgl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic t, input logic b);
        @(negedge clk);
        tick_en = t; blank = b;
        @(posedge clk);
        #1;
    endtask

    task automatic toggle();
        @(negedge clk);
        zc_tgl = ~zc_tgl; tick_en = 1'b0; blank = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic measure(input int lim, input logic b, output int first, output int highs);
        first = 0; highs = 0;
        for (int i = 1; i <= lim; i++) begin
            step(1'b1, b);
            if (commute) begin
                highs++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        #3000000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int first, highs;
        string tag;

        // R1: reset state, ticks alone never commute
        do_reset();
        chk("R1 reset level", commute, 0);
        measure(20, 1'b0, first, highs);
        chk("R1 ticks without toggle", highs, 0);

        // table walk: measure interval, then replay
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            toggle();
            chk("R2 first toggle", commute, 0);
            highs = 0;
            for (int j = 0; j < VEC[v][0]; j++) begin
                step(1'b1, j < VEC[v][1]);
                if (commute) highs++;
            end
            chk("R2 no pulse while measuring", highs, 0);
            toggle();
            chk("R2 handover without force", commute, 0);
            measure(VEC[v][0] + 6, 1'b0, first, highs);
            tag = (VEC[v][2] == 0) ? "R9" : ((VEC[v][1] != 0) ? "R3" : "R4");
            chk(tag, first, VEC[v][2]);
            chk("R8 pulse count", highs, (VEC[v][2] == 0) ? 0 : 1);
        end

        // R5: no tick, no movement; value kept for later replay
        do_reset();
        toggle();
        for (int j = 0; j < 6; j++) step(1'b1, 1'b0);
        toggle();
        measure(30, 1'b0, first, highs);
        first = 0; highs = 0;
        for (int j = 0; j < 30; j++) begin
            step(1'b0, 1'b0);
            if (commute) highs++;
        end
        chk("R5 idle ticks", highs, 0);
        do_reset();
        toggle();
        for (int j = 0; j < 6; j++) step(1'b1, 1'b0);
        toggle();
        highs = 0;
        for (int j = 0; j < 30; j++) begin
            step(1'b0, 1'b0);
            if (commute) highs++;
        end
        chk("R5 no pulse without tick", highs, 0);
        measure(10, 1'b0, first, highs);
        chk("R5 replay unchanged", first, 3);

        // R4: blanking does not slow the replay
        do_reset();
        toggle();
        for (int j = 0; j < 8; j++) step(1'b1, 1'b0);
        toggle();
        measure(12, 1'b1, first, highs);
        chk("R4 replay ignores blank", first, 4);

        // R6: saturation of the measuring counter
        do_reset();
        toggle();
        for (int j = 0; j < 3400; j++) step(1'b1, 1'b0);
        toggle();
        measure(1700, 1'b0, first, highs);
        chk("R6 saturated replay", first, 1636);

        // R7 and R8: early toggle forces commutation, replay holds one cycle
        do_reset();
        toggle();
        for (int j = 0; j < 20; j++) step(1'b1, 1'b0);
        toggle();
        measure(3, 1'b0, first, highs);
        chk("R7 no pulse before early toggle", highs, 0);
        toggle();
        chk("R7 forced pulse", commute, 1);
        step(1'b1, 1'b0);
        chk("R8 pulse ends, replay holds", commute, 0);
        step(1'b1, 1'b0);
        chk("R8 replay second tick", commute, 0);
        step(1'b1, 1'b0);
        chk("R7 swapped replay completes", commute, 1);
        step(1'b1, 1'b0);
        chk("R8 single cycle", commute, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule